// File: doc/BRIEF.md
# Exception Entry Context Controller

This block makes every control-state update that a core performs when it takes a trap: a synchronous exception, an external interrupt or a debug breakpoint. The pipeline presents a cause (major code plus subcode), the faulting PC, the instruction word fetched at that PC, a flag saying a TLB refill is in progress, the current mode bits, the masked interrupt lines and the entry configuration (entry base, refill entry, vector spacing select). When `take` is high on a rising edge, the block commits all register updates for that trap in that one edge. On the next cycle it presents the redirect PC with a one-cycle `redirect_vld` pulse, or a one-cycle `code_err` pulse if the cause is not supported.

Each trap follows one of three save paths. The debug path fills the debug return register and jumps to a fixed offset from the entry base. The refill path fills the refill saved-mode and refill return registers and normally jumps to the refill entry. The normal path writes the cause fields, the saved-mode register and the exception return register, and jumps to a vectored entry. A two-state machine tracks debug mode: `ST_NORMAL` (reset state) and `ST_DEBUG`. The transition `ST_NORMAL -> ST_DEBUG` fires on a taken breakpoint. `ST_DEBUG` has only a self-loop, because leaving debug mode belongs to the return instruction, which is outside this block; reset is the only way back. In `ST_DEBUG`, interrupts are steered into the debug path. Other exceptions in `ST_DEBUG` still use the refill or normal path.

Cause encoding (major, subcode 0 unless noted): interrupt 0, load page-invalid 1, store page-invalid 2, fetch page-invalid 3, page-modified 4, not-readable 5, not-executable 6, privilege 7, address error 8 (subcode 0 fetch, 1 data access), bound check 10, syscall 11, break 12, illegal instruction 13, instruction privilege 14, FP disabled 15, 128-bit vector disabled 16, 256-bit vector disabled 17, FP exception 18, debug breakpoint 26.

Top module: `exc_entry_ctl`

## Requirements
- R1: After reset, all saved registers, cause fields and debug fields are 0, the mode image reads PLV=0, IE=0, DA=1, PG=0, and `redirect_vld` and `code_err` are 0.
- R2: A taken breakpoint (major 26) sets DCL=1, sets the debug cause field to 0xC, copies the PC into `dera`, sets DST=1 and redirects to `entry_base + 0x480`. The mode image, `era`, `rera`, both saved-mode registers, `badv`, `badi` and the cause fields are left unchanged. DST stays 1 until reset.
- R3: An interrupt taken while DST=1 sets DEI=1 and copies the PC into `dera`. It redirects to `entry_base + 0x480` and leaves every other register unchanged.
- R4: Majors 11 to 18 (syscall, break, illegal instruction, instruction privilege, FP disabled, both vector-disabled codes, FP exception) copy the PC into `badv`. No other cause changes `badv`.
- R5: On the refill and normal paths, `badi` is loaded with `cur_inst` for every cause except the interrupt, fetch page-invalid (3) and fetch address error (8 with subcode 0).
- R6: With `refill_active`=1 on a non-debug trap, the refill saved-mode register takes the current PLV and IE, the mode image gets DA=1 and PG=0, and `rera` takes PC>>2. For non-interrupt causes the redirect is `refill_entry`. `era`, the saved-mode register and the cause fields are unchanged.
- R7: On the normal path, the cause major and subcode are written to `stat_ecode`/`stat_esub`, the current PLV and IE go to the saved-mode register, and the PC goes to `era`. DA and PG are copied from the current mode.
- R8: On both the refill and normal paths the mode image gets PLV=0 and IE=0.
- R9: A normal-path non-interrupt trap redirects to `entry_base + major*S`. S is 0 when `vec_sel`=0 and `4<<vec_sel` otherwise.
- R10: An interrupt outside debug mode picks the highest-numbered set bit `v` of `irq_lines` and redirects to `entry_base + (64+v)*S`. This holds on the refill path too. It leaves `badv` and `badi` unchanged.
- R11: An unsupported cause produces a one-cycle `code_err` pulse, no `redirect_vld` and no register change. Unsupported means an unlisted major, a nonzero subcode other than subcode 1 of major 8, or an interrupt with no line set.
- R12: With `take` low nothing changes. `redirect_vld` and `code_err` are single-cycle pulses that appear in the cycle after the taking edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take | input | 1 | Commit the presented trap on this edge |
| exc_major | input | 6 | Cause major code |
| exc_sub | input | 9 | Cause subcode |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_inst | input | 32 | Instruction word at `cur_pc` |
| refill_active | input | 1 | TLB refill in progress |
| cur_plv | input | 2 | Current privilege level |
| cur_ie | input | 1 | Current interrupt enable |
| cur_da | input | 1 | Current direct-address mode |
| cur_pg | input | 1 | Current paged mode |
| irq_lines | input | NIRQ | Pending and enabled interrupt lines |
| entry_base | input | XLEN | Exception entry base |
| refill_entry | input | XLEN | Refill entry address |
| vec_sel | input | 3 | Vector spacing select |
| mode_plv | output | 2 | Mode image: PLV |
| mode_ie | output | 1 | Mode image: IE |
| mode_da | output | 1 | Mode image: DA |
| mode_pg | output | 1 | Mode image: PG |
| sv_plv | output | 2 | Saved-mode PLV |
| sv_ie | output | 1 | Saved-mode IE |
| rsv_plv | output | 2 | Refill saved-mode PLV |
| rsv_ie | output | 1 | Refill saved-mode IE |
| era | output | XLEN | Exception return address |
| rera | output | XLEN-2 | Refill return address (PC>>2) |
| dera | output | XLEN | Debug return address |
| badv | output | XLEN | Bad virtual address |
| badi | output | 32 | Bad instruction |
| stat_ecode | output | 6 | Status cause major |
| stat_esub | output | 9 | Status cause subcode |
| dbg_dst | output | 1 | Debug mode active |
| dbg_dcl | output | 1 | Debug entered by breakpoint |
| dbg_dei | output | 1 | Debug entry by interrupt |
| dbg_ecode | output | 6 | Debug cause field |
| redirect_pc | output | XLEN | New PC |
| redirect_vld | output | 1 | New PC valid pulse |
| code_err | output | 1 | Unsupported cause pulse |

## Verification
The bench builds the block with XLEN=32 and NIRQ=13. This keeps a 64-entry-plus-line vector index well inside the address width at the largest spacing (`vec_sel`=7), so the multiply-and-add can be checked exactly. Thirteen lines let the highest-priority pick be exercised at both the top line (12) and a middle line (8). With these widths the bench also reaches spacing 0, the refill-entry versus vectored-interrupt choice during refill, and interrupt redirection into debug mode.

// File: rtl/exc_ctx_pkg.sv
package exc_ctx_pkg;

    localparam int MAJ_W = 6;
    localparam int SUB_W = 9;

    localparam logic [MAJ_W-1:0] C_INT  = 6'd0;
    localparam logic [MAJ_W-1:0] C_PIL  = 6'd1;
    localparam logic [MAJ_W-1:0] C_PIS  = 6'd2;
    localparam logic [MAJ_W-1:0] C_PIF  = 6'd3;
    localparam logic [MAJ_W-1:0] C_PME  = 6'd4;
    localparam logic [MAJ_W-1:0] C_PNR  = 6'd5;
    localparam logic [MAJ_W-1:0] C_PNX  = 6'd6;
    localparam logic [MAJ_W-1:0] C_PPI  = 6'd7;
    localparam logic [MAJ_W-1:0] C_ADE  = 6'd8;
    localparam logic [MAJ_W-1:0] C_BCE  = 6'd10;
    localparam logic [MAJ_W-1:0] C_SYS  = 6'd11;
    localparam logic [MAJ_W-1:0] C_BRK  = 6'd12;
    localparam logic [MAJ_W-1:0] C_INE  = 6'd13;
    localparam logic [MAJ_W-1:0] C_IPE  = 6'd14;
    localparam logic [MAJ_W-1:0] C_FPD  = 6'd15;
    localparam logic [MAJ_W-1:0] C_SXD  = 6'd16;
    localparam logic [MAJ_W-1:0] C_ASXD = 6'd17;
    localparam logic [MAJ_W-1:0] C_FPE  = 6'd18;
    localparam logic [MAJ_W-1:0] C_DBP  = 6'd26;

    localparam logic [MAJ_W-1:0] DBG_CAUSE   = 6'hC;
    localparam int               DBG_OFFSET  = 'h480;
    localparam int               IRQ_VEC_BASE = 64;

    typedef enum logic [1:0] {
        PATH_NONE   = 2'd0,
        PATH_DEBUG  = 2'd1,
        PATH_REFILL = 2'd2,
        PATH_NORMAL = 2'd3
    } path_e;

    typedef struct packed {
        path_e path;
        logic  wr_badv;
        logic  wr_badi;
        logic  is_int;
        logic  is_dbp;
    } exc_class_t;

    typedef enum logic {
        ST_NORMAL = 1'b0,
        ST_DEBUG  = 1'b1
    } dstate_e;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_ctx_pkg::*;
(
    input  logic [MAJ_W-1:0] maj,
    input  logic [SUB_W-1:0] sub,
    input  logic             in_debug,
    input  logic             refill,
    input  logic             irq_any,
    output exc_class_t       cls
);

    logic known;
    logic sub_zero;
    logic wbadv;
    logic wbadi;
    logic isint;
    logic isdbp;

    assign sub_zero = (sub == '0);

    always_comb begin
        known = 1'b0;
        wbadv = 1'b0;
        wbadi = 1'b1;
        isint = 1'b0;
        isdbp = 1'b0;
        unique case (maj)
            C_INT: begin
                known = sub_zero && irq_any;
                isint = 1'b1;
                wbadi = 1'b0;
            end
            C_PIF: begin
                known = sub_zero;
                wbadi = 1'b0;
            end
            C_ADE: begin
                known = (sub <= SUB_W'(1));
                wbadi = !sub_zero;
            end
            C_PIL, C_PIS, C_PME, C_PNR, C_PNX, C_PPI, C_BCE: begin
                known = sub_zero;
            end
            C_SYS, C_BRK, C_INE, C_IPE, C_FPD, C_SXD, C_ASXD, C_FPE: begin
                known = sub_zero;
                wbadv = 1'b1;
            end
            C_DBP: begin
                known = sub_zero;
                isdbp = 1'b1;
            end
            default: known = 1'b0;
        endcase
    end

    always_comb begin
        cls.is_int = isint;
        cls.is_dbp = isdbp;
        if (!known) begin
            cls.path = PATH_NONE;
        end else if (isdbp || (isint && in_debug)) begin
            cls.path = PATH_DEBUG;
        end else if (refill) begin
            cls.path = PATH_REFILL;
        end else begin
            cls.path = PATH_NORMAL;
        end
        cls.wr_badv = wbadv && (cls.path == PATH_REFILL || cls.path == PATH_NORMAL);
        cls.wr_badi = wbadi && (cls.path == PATH_REFILL || cls.path == PATH_NORMAL);
    end

endmodule

// File: rtl/exc_irq_pick.sv
module exc_irq_pick #(
    parameter int NIRQ  = 13,
    parameter int VEC_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic [NIRQ-1:0]  lines,
    output logic [VEC_W-1:0] vec,
    output logic             any
);

    always_comb begin
        vec = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (lines[i]) vec = VEC_W'(i);
        end
    end

    assign any = |lines;

endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
    import exc_ctx_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 4
) (
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  refill_entry,
    input  logic [2:0]       vs,
    input  logic [MAJ_W-1:0] maj,
    input  logic [VEC_W-1:0] vec,
    input  exc_class_t       cls,
    output logic [XLEN-1:0]  target
);

    logic [XLEN-1:0] idx;
    logic [XLEN-1:0] off;
    logic [3:0]      shamt;

    assign shamt = {1'b0, vs} + 4'd2;

    always_comb begin
        if (cls.is_int) idx = XLEN'(IRQ_VEC_BASE) + XLEN'(vec);
        else            idx = XLEN'(maj);
        off = (vs == 3'd0) ? '0 : (idx << shamt);
    end

    always_comb begin
        unique case (cls.path)
            PATH_DEBUG:  target = base + XLEN'(DBG_OFFSET);
            PATH_REFILL: target = cls.is_int ? (base + off) : refill_entry;
            PATH_NORMAL: target = base + off;
            default:     target = base;
        endcase
    end

endmodule

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
    import exc_ctx_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NIRQ = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [5:0]          exc_major,
    input  logic [8:0]          exc_sub,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic [31:0]         cur_inst,
    input  logic                refill_active,
    input  logic [1:0]          cur_plv,
    input  logic                cur_ie,
    input  logic                cur_da,
    input  logic                cur_pg,
    input  logic [NIRQ-1:0]     irq_lines,
    input  logic [XLEN-1:0]     entry_base,
    input  logic [XLEN-1:0]     refill_entry,
    input  logic [2:0]          vec_sel,
    output logic [1:0]          mode_plv,
    output logic                mode_ie,
    output logic                mode_da,
    output logic                mode_pg,
    output logic [1:0]          sv_plv,
    output logic                sv_ie,
    output logic [1:0]          rsv_plv,
    output logic                rsv_ie,
    output logic [XLEN-1:0]     era,
    output logic [XLEN-3:0]     rera,
    output logic [XLEN-1:0]     dera,
    output logic [XLEN-1:0]     badv,
    output logic [31:0]         badi,
    output logic [5:0]          stat_ecode,
    output logic [8:0]          stat_esub,
    output logic                dbg_dst,
    output logic                dbg_dcl,
    output logic                dbg_dei,
    output logic [5:0]          dbg_ecode,
    output logic [XLEN-1:0]     redirect_pc,
    output logic                redirect_vld,
    output logic                code_err
);

    localparam int VEC_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    dstate_e          state_q;
    dstate_e          state_d;
    exc_class_t       cls;
    logic [VEC_W-1:0] irq_vec;
    logic             irq_any;
    logic [XLEN-1:0]  target;
    logic             do_dbg;
    logic             do_rfl;
    logic             do_nrm;

    exc_irq_pick #(.NIRQ(NIRQ), .VEC_W(VEC_W)) u_pick (
        .lines (irq_lines),
        .vec   (irq_vec),
        .any   (irq_any)
    );

    exc_classify u_cls (
        .maj      (exc_major),
        .sub      (exc_sub),
        .in_debug (state_q == ST_DEBUG),
        .refill   (refill_active),
        .irq_any  (irq_any),
        .cls      (cls)
    );

    exc_target_calc #(.XLEN(XLEN), .VEC_W(VEC_W)) u_tgt (
        .base         (entry_base),
        .refill_entry (refill_entry),
        .vs           (vec_sel),
        .maj          (exc_major),
        .vec          (irq_vec),
        .cls          (cls),
        .target       (target)
    );

    assign do_dbg = take && (cls.path == PATH_DEBUG);
    assign do_rfl = take && (cls.path == PATH_REFILL);
    assign do_nrm = take && (cls.path == PATH_NORMAL);

    // Debug-mode state machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: if (do_dbg) state_d = ST_DEBUG;
            ST_DEBUG:  state_d = ST_DEBUG;
            default:   state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    assign dbg_dst = (state_q == ST_DEBUG);

    // Register updates, all committed on the taking edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_plv     <= 2'd0;
            mode_ie      <= 1'b0;
            mode_da      <= 1'b1;
            mode_pg      <= 1'b0;
            sv_plv       <= 2'd0;
            sv_ie        <= 1'b0;
            rsv_plv      <= 2'd0;
            rsv_ie       <= 1'b0;
            era          <= '0;
            rera         <= '0;
            dera         <= '0;
            badv         <= '0;
            badi         <= '0;
            stat_ecode   <= '0;
            stat_esub    <= '0;
            dbg_dcl      <= 1'b0;
            dbg_dei      <= 1'b0;
            dbg_ecode    <= '0;
            redirect_pc  <= '0;
            redirect_vld <= 1'b0;
            code_err     <= 1'b0;
        end else begin
            redirect_vld <= take && (cls.path != PATH_NONE);
            code_err     <= take && (cls.path == PATH_NONE);
            if (take && (cls.path != PATH_NONE)) redirect_pc <= target;

            if (do_dbg) begin
                dera <= cur_pc;
                if (cls.is_dbp) begin
                    dbg_dcl   <= 1'b1;
                    dbg_ecode <= DBG_CAUSE;
                end
                if (cls.is_int) dbg_dei <= 1'b1;
            end

            if (take && cls.wr_badv) badv <= cur_pc;
            if (take && cls.wr_badi) badi <= cur_inst;

            if (do_rfl) begin
                rsv_plv  <= cur_plv;
                rsv_ie   <= cur_ie;
                rera     <= cur_pc[XLEN-1:2];
                mode_plv <= 2'd0;
                mode_ie  <= 1'b0;
                mode_da  <= 1'b1;
                mode_pg  <= 1'b0;
            end

            if (do_nrm) begin
                stat_ecode <= exc_major;
                stat_esub  <= exc_sub;
                sv_plv     <= cur_plv;
                sv_ie      <= cur_ie;
                era        <= cur_pc;
                mode_plv   <= 2'd0;
                mode_ie    <= 1'b0;
                mode_da    <= cur_da;
                mode_pg    <= cur_pg;
            end
        end
    end

endmodule

// File: rtl/exc_entry_ctl_chk.sv
module exc_entry_ctl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take,
    input logic [1:0]      mode_plv,
    input logic            mode_ie,
    input logic [XLEN-1:0] era,
    input logic [XLEN-1:0] badv,
    input logic [31:0]     badi,
    input logic [XLEN-1:0] dera,
    input logic            dbg_dst,
    input logic            redirect_vld,
    input logic            code_err
);

    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> (!redirect_vld && !code_err)); // R12

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_vld && code_err)); // R11

    AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> ($stable(era) && $stable(badv) && $stable(badi) && $stable(dera))); // R11

    AST_DST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_dst |=> dbg_dst); // R2

    AST_TRAP_CLEARS_PLV: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && !dbg_dst && $stable(dbg_dst)) |-> (mode_plv == 2'd0 && !mode_ie)); // R8

    AST_DEBUG_ENTRY_KEEPS_ERA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_dst) |-> ($stable(era) && $stable(badi))); // R2

endmodule

bind exc_entry_ctl exc_entry_ctl_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .mode_plv     (mode_plv),
    .mode_ie      (mode_ie),
    .era          (era),
    .badv         (badv),
    .badi         (badi),
    .dera         (dera),
    .dbg_dst      (dbg_dst),
    .redirect_vld (redirect_vld),
    .code_err     (code_err)
);

// File: tb/exc_entry_ctl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctl_bench;

    localparam int XLEN = 32;
    localparam int NIRQ = 13;
    localparam int NVEC = 15;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            take;
    logic [5:0]      exc_major;
    logic [8:0]      exc_sub;
    logic [XLEN-1:0] cur_pc;
    logic [31:0]     cur_inst;
    logic            refill_active;
    logic [1:0]      cur_plv;
    logic            cur_ie, cur_da, cur_pg;
    logic [NIRQ-1:0] irq_lines;
    logic [XLEN-1:0] entry_base, refill_entry;
    logic [2:0]      vec_sel;
    logic [1:0]      mode_plv, sv_plv, rsv_plv;
    logic            mode_ie, mode_da, mode_pg, sv_ie, rsv_ie;
    logic [XLEN-1:0] era, dera, badv, redirect_pc;
    logic [XLEN-3:0] rera;
    logic [31:0]     badi;
    logic [5:0]      stat_ecode, dbg_ecode;
    logic [8:0]      stat_esub;
    logic            dbg_dst, dbg_dcl, dbg_dei, redirect_vld, code_err;

    always #5 clk = ~clk;

    exc_entry_ctl #(.XLEN(XLEN), .NIRQ(NIRQ)) u_exc_entry_ctl (.*);

    int checks = 0;
    int errors = 0;

    // expected state
    logic [1:0]  e_mplv, e_splv, e_rplv;
    logic        e_mie, e_mda, e_mpg, e_sie, e_rie;
    logic [31:0] e_era, e_dera, e_badv, e_badi, e_rpc;
    logic [29:0] e_rera;
    logic [5:0]  e_ecode, e_decode;
    logic [8:0]  e_esub;
    logic        e_dst, e_dcl, e_dei, e_vld, e_err;

    // vector: {major[31:26], sub[25:17], refill[16], vs[15:13], irq[12:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {6'd11, 9'd0, 1'b0, 3'd0, 13'h0},
        {6'd12, 9'd0, 1'b0, 3'd3, 13'h0},
        {6'd1,  9'd0, 1'b0, 3'd1, 13'h0},
        {6'd3,  9'd0, 1'b0, 3'd2, 13'h0},
        {6'd8,  9'd1, 1'b0, 3'd7, 13'h0},
        {6'd8,  9'd0, 1'b1, 3'd2, 13'h0},
        {6'd18, 9'd0, 1'b0, 3'd4, 13'h0},
        {6'd16, 9'd0, 1'b1, 3'd1, 13'h0},
        {6'd0,  9'd0, 1'b0, 3'd2, 13'h0104},
        {6'd0,  9'd0, 1'b1, 3'd1, 13'h1000},
        {6'd17, 9'd0, 1'b0, 3'd5, 13'h0},
        {6'd10, 9'd0, 1'b0, 3'd6, 13'h0},
        {6'd9,  9'd0, 1'b0, 3'd1, 13'h0},
        {6'd0,  9'd0, 1'b0, 3'd1, 13'h0},
        {6'd4,  9'd3, 1'b0, 3'd1, 13'h0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        e_mplv = 0; e_mie = 0; e_mda = 1; e_mpg = 0;
        e_splv = 0; e_sie = 0; e_rplv = 0; e_rie = 0;
        e_era = 0; e_rera = 0; e_dera = 0; e_badv = 0; e_badi = 0;
        e_ecode = 0; e_esub = 0; e_dst = 0; e_dcl = 0; e_dei = 0; e_decode = 0;
        e_rpc = 0; e_vld = 0; e_err = 0;
    endtask

    task automatic model_take();
        logic ok, intr, dbp, nobadi, setbadv;
        int v;
        logic [31:0] sp;
        ok = 0; intr = (exc_major == 0); dbp = (exc_major == 26);
        v = 0;
        for (int i = 0; i < NIRQ; i++) if (irq_lines[i]) v = i;
        if (exc_major == 8) ok = (exc_sub <= 1);
        else if (exc_sub == 0)
            ok = (exc_major <= 7) || (exc_major >= 10 && exc_major <= 18) || dbp;
        if (intr && irq_lines == 0) ok = 0;
        setbadv = (exc_major >= 11 && exc_major <= 18);
        nobadi = intr || exc_major == 3 || (exc_major == 8 && exc_sub == 0);
        sp = (vec_sel == 0) ? 32'd0 : (32'd4 << vec_sel);
        e_vld = ok; e_err = !ok;
        if (!ok) return;
        if (dbp || (intr && e_dst)) begin
            e_dera = cur_pc; e_dst = 1;                             // R2 R3
            if (dbp) begin e_dcl = 1; e_decode = 6'hC; end
            else e_dei = 1;
            e_rpc = entry_base + 32'h480;
            return;
        end
        if (setbadv) e_badv = cur_pc;                                // R4
        if (!nobadi) e_badi = cur_inst;                              // R5
        if (refill_active) begin                                     // R6
            e_rplv = cur_plv; e_rie = cur_ie; e_rera = cur_pc[31:2];
            e_mda = 1; e_mpg = 0;
        end else begin                                               // R7
            e_ecode = exc_major; e_esub = exc_sub;
            e_splv = cur_plv; e_sie = cur_ie; e_era = cur_pc;
            e_mda = cur_da; e_mpg = cur_pg;
        end
        e_mplv = 0; e_mie = 0;                                       // R8
        if (intr) e_rpc = entry_base + (32'(64 + v)) * sp;           // R10
        else if (refill_active) e_rpc = refill_entry;
        else e_rpc = entry_base + 32'(exc_major) * sp;               // R9
    endtask

    task automatic check_all(input string req);
        chk({req, " mode"}, {mode_plv, mode_ie, mode_da, mode_pg}, {e_mplv, e_mie, e_mda, e_mpg});
        chk({req, " saved"}, {sv_plv, sv_ie, rsv_plv, rsv_ie}, {e_splv, e_sie, e_rplv, e_rie});
        chk({req, " era"}, era, e_era);
        chk({req, " rera"}, rera, e_rera);
        chk({req, " dera"}, dera, e_dera);
        chk({req, " badv"}, badv, e_badv);
        chk({req, " badi"}, badi, e_badi);
        chk({req, " cause"}, {stat_ecode, stat_esub}, {e_ecode, e_esub});
        chk({req, " debug"}, {dbg_dst, dbg_dcl, dbg_dei, dbg_ecode}, {e_dst, e_dcl, e_dei, e_decode});
        chk({req, " pulses"}, {redirect_vld, code_err}, {e_vld, e_err});
        if (e_vld) chk({req, " redirect"}, redirect_pc, e_rpc);
    endtask

    task automatic apply(input string req, input logic [5:0] maj, input logic [8:0] sub,
                         input logic rf, input logic [2:0] vs, input logic [NIRQ-1:0] irq,
                         input logic [31:0] pc);
        @(negedge clk);
        take = 1; exc_major = maj; exc_sub = sub; refill_active = rf; vec_sel = vs;
        irq_lines = irq; cur_pc = pc; cur_inst = ~pc ^ 32'h0F0F_1234;
        cur_plv = pc[7:6]; cur_ie = pc[8]; cur_da = pc[9]; cur_pg = !pc[9];
        model_take();
        @(posedge clk); #1;
        check_all(req);
        @(negedge clk);
        take = 0;
        e_vld = 0; e_err = 0;
        @(posedge clk); #1;
        chk({req, " R12 pulse width"}, {redirect_vld, code_err}, 2'b00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; take = 0;
        @(posedge clk); @(posedge clk); #1;
        model_reset();
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; take = 0; exc_major = 0; exc_sub = 0; cur_pc = 0; cur_inst = 0;
        refill_active = 0; cur_plv = 0; cur_ie = 0; cur_da = 0; cur_pg = 0;
        irq_lines = 0; entry_base = 32'h1C00_0000; refill_entry = 32'h9000_4000; vec_sel = 0;
        do_reset();
        @(posedge clk); #1;
        check_all("R1 reset");

        for (int i = 0; i < NVEC; i++) begin
            apply($sformatf("R4 R5 R6 R7 R9 R10 R11 vec%0d", i), VEC[i][31:26], VEC[i][25:17],
                  VEC[i][16], VEC[i][15:13], VEC[i][12:0], 32'h4000_0000 + 32'(i) * 32'h1C4);
        end

        // R12: take low with a valid cause presented changes nothing
        @(negedge clk);
        take = 0; exc_major = 6'd11; exc_sub = 0; cur_pc = 32'hDEAD_0000; irq_lines = 13'h1;
        repeat (3) @(posedge clk); #1;
        check_all("R12 idle");

        // R2 breakpoint then R3 interrupt in debug, then R7 sys in debug
        apply("R2 breakpoint", 6'd26, 9'd0, 1'b0, 3'd3, 13'h0, 32'h5000_0100);
        apply("R3 irq in debug", 6'd0, 9'd0, 1'b1, 3'd3, 13'h0010, 32'h5000_0200);
        apply("R7 sys in debug", 6'd11, 9'd0, 1'b0, 3'd2, 13'h0, 32'h5000_0344);
        apply("R11 irq none in debug", 6'd0, 9'd0, 1'b0, 3'd2, 13'h0, 32'h5000_0400);

        do_reset();
        @(posedge clk); #1;
        check_all("R1 reset clears debug");
        apply("R6 refill ine", 6'd13, 9'd0, 1'b1, 3'd1, 13'h0, 32'h6000_07FC);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule